// File: doc/BRIEF.md
# Bit-Serial SIMD Pixel Processing Element

This block is one cell of a processor-per-pixel array. A central sequencer broadcasts the same instruction to every cell at the same time. Each cell runs it through a one-bit ALU, least significant bit first, over a full register width. Each cell holds a small register file and a one-bit condition flag. The flag lets a cell skip the write-back of a broadcast instruction, so cells can act differently on the same instruction without branching.

Operand A always comes from the register file. Operand B comes either from the destination register (an accumulator form) or, bit by bit, from one of the four grid neighbours. The cell puts operand A on its serial output during the same pass. Adjacent cells that start together can therefore exchange data and combine it (add, AND, OR, XOR, copy) while it moves. A load port writes pixel data into any register while the cell is idle. A read port returns any register.

Top module: `serial_pe`

## Requirements
- R1: After reset every register reads 0, `flag` is 0, `busy` is 0 and `ser_out` is 0.
- R2: With `ld_en` high, `busy` low and `issue` low, `ld_data` is written to register `ld_addr` at the clock edge and is readable on `rd_data` (selected by `rd_addr`) after that edge. A load requested while `busy` is high is ignored.
- R3: `issue` sampled high while `busy` is low starts an instruction. `busy` then stays high for exactly DATA_W (8) cycles, and the result is committed on the last of them. `issue` asserted while `busy` is high is ignored.
- R4: Opcode 0 (add) writes (A + B) mod 256 to the destination. Its carry-out is the bit above the sum.
- R5: Opcode 1 (subtract) writes (A − B) mod 256 to the destination. Its carry-out is 1 exactly when A ≥ B.
- R6: Opcodes 2 AND, 3 OR, 4 XOR, 5 copy A, 6 copy B and 7 invert A produce the bitwise result. Their carry-out is 0.
- R7: `instr_regs` carries the A register index in bits [2:0], the destination index in [5:3] and the neighbour select in [7:6]. With `instr_nbr` high, B is `nbr_in[select]` (0 north, 1 east, 2 south, 3 west). Bit k of B is sampled at the (k+1)-th rising edge after the issuing edge.
- R8: During an instruction, `ser_out` carries bit k of A in the cycle after the k-th edge following the issuing edge (k = 0 at the issuing edge). It is 0 while the cell is idle.
- R9: `instr_fmode` updates the flag at commit: 0 keeps it, 1 loads the carry-out, 2 loads "result is zero", 3 loads "result is non-zero".
- R10: With `instr_fen` high and the flag 0 when the instruction commits, the destination register is left unchanged. The flag update of R9 still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Start the broadcast instruction |
| instr_op | input | 3 | ALU function code |
| instr_regs | input | 8 | {neighbour select, destination index, A index} |
| instr_nbr | input | 1 | Take operand B from the selected neighbour |
| instr_fmode | input | 2 | Flag update mode |
| instr_fen | input | 1 | Make write-back conditional on the flag |
| nbr_in | input | 4 | Serial bits from north, east, south, west |
| ser_out | output | 1 | Serial operand stream toward neighbours |
| busy | output | 1 | Instruction in progress |
| flag | output | 1 | Condition flag |
| ld_en | input | 1 | Pixel load strobe |
| ld_addr | input | 3 | Load register index |
| ld_data | input | 8 | Load value |
| rd_addr | input | 3 | Readout register index |
| rd_data | output | 8 | Readout value |

## Verification
The embedded properties assume that the neighbour bits change only between edges. They also assume that `rd_addr` is held steady whenever the register-hold property is meant to bite, so that property compares the readout only when the address is unchanged. The bench drives every input on the falling edge. It changes `rd_addr` only while idle, and it holds all neighbour lanes other than the selected one at the inverse of the wanted bit, so a wrong lane selection shows up in the result. Loads and re-issues during a pass are injected on purpose, away from the commit cycle.

// File: rtl/pe_pkg.sv
package pe_pkg;
   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_AND  = 3'd2,
      OP_OR   = 3'd3,
      OP_XOR  = 3'd4,
      OP_MOVA = 3'd5,
      OP_MOVB = 3'd6,
      OP_NOTA = 3'd7
   } pe_op_e;

   typedef enum logic [1:0] {
      FL_KEEP  = 2'd0,
      FL_CARRY = 2'd1,
      FL_ZERO  = 2'd2,
      FL_NZERO = 2'd3
   } pe_fmode_e;

   // carry register start value for a pass
   function automatic logic carry_seed(pe_op_e op);
      return op == OP_SUB;
   endfunction
endpackage

// File: rtl/pe_regfile.sv
module pe_regfile #(
   parameter int DATA_W = 8,
   parameter int NREGS  = 8,
   localparam int AW    = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [AW-1:0]     raddr_b,
   output logic [DATA_W-1:0] rdata_b,
   input  logic [AW-1:0]     raddr_c,
   output logic [DATA_W-1:0] rdata_c
);
   if (NREGS < 2 || (1 << AW) != NREGS) begin : g_bad_depth
      $error("pe_regfile: NREGS must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] mem [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_word
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        q <= '0;
         else if (we && waddr == AW'(g))    q <= wdata;
      end
      assign mem[g] = q;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
   assign rdata_c = mem[raddr_c];

   // R2
   wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (raddr_c != $past(waddr)) || (rdata_c == $past(wdata)));
endmodule

// File: rtl/pe_nbr_mux.sv
module pe_nbr_mux #(
   parameter int NNBR = 4,
   localparam int NW  = (NNBR > 1) ? $clog2(NNBR) : 1
) (
   input  logic [NNBR-1:0] nbr_in,
   input  logic [NW-1:0]   sel,
   input  logic            use_nbr,
   input  logic            own_bit,
   output logic            b_bit
);
   if (NNBR < 1) begin : g_bad_nbr
      $error("pe_nbr_mux: NNBR must be at least 1");
   end

   logic lane;
   if ((1 << NW) == NNBR) begin : g_full
      assign lane = nbr_in[sel];
   end else begin : g_guarded
      always_comb begin
         lane = 1'b0;
         for (int i = 0; i < NNBR; i++)
            if (int'(sel) == i) lane = nbr_in[i];
      end
   end

   assign b_bit = use_nbr ? lane : own_bit;
endmodule

// File: rtl/pe_bit_alu.sv
module pe_bit_alu
   import pe_pkg::*;
(
   input  pe_op_e op,
   input  logic   a,
   input  logic   b,
   input  logic   cin,
   output logic   r,
   output logic   cout
);
   logic bx;
   assign bx = (op == OP_SUB) ? ~b : b;

   always_comb begin
      r    = 1'b0;
      cout = 1'b0;
      unique case (op)
         OP_ADD, OP_SUB: begin
            r    = a ^ bx ^ cin;
            cout = (a & bx) | (a & cin) | (bx & cin);
         end
         OP_AND:  r = a & b;
         OP_OR:   r = a | b;
         OP_XOR:  r = a ^ b;
         OP_MOVA: r = a;
         OP_MOVB: r = b;
         OP_NOTA: r = ~a;
         default: r = 1'b0;
      endcase
   end

   // R4
   always_comb begin
      if (op == OP_ADD)
         add_sum_chk: assert ({cout, r} == (2'(a) + 2'(b) + 2'(cin)));
   end
endmodule

// File: rtl/serial_pe.sv
module serial_pe
   import pe_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NREGS  = 8,
   parameter int NNBR   = 4,
   localparam int AW    = $clog2(NREGS),
   localparam int NW    = (NNBR > 1) ? $clog2(NNBR) : 1,
   localparam int IW    = 2 * AW + NW,
   localparam int CW    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [2:0]        instr_op,
   input  logic [IW-1:0]     instr_regs,
   input  logic              instr_nbr,
   input  logic [1:0]        instr_fmode,
   input  logic              instr_fen,
   input  logic [NNBR-1:0]   nbr_in,
   output logic              ser_out,
   output logic              busy,
   output logic              flag,
   input  logic              ld_en,
   input  logic [AW-1:0]     ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   if (DATA_W < 2 || (1 << CW) != DATA_W) begin : g_bad_width
      $error("serial_pe: DATA_W must be a power of two, at least 2");
   end

   localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

   // instruction field split
   logic [AW-1:0] f_src, f_dst;
   logic [NW-1:0] f_nsel;
   assign f_src  = instr_regs[AW-1:0];
   assign f_dst  = instr_regs[2*AW-1:AW];
   assign f_nsel = instr_regs[IW-1:2*AW];

   // latched instruction
   pe_op_e        q_op;
   pe_fmode_e     q_fmode;
   logic [AW-1:0] q_dst;
   logic [NW-1:0] q_nsel;
   logic          q_nbr, q_fen;

   logic              busy_q, flag_q, carry_q;
   logic [CW-1:0]     cnt_q;
   logic [DATA_W-1:0] opa_q, opb_q, shout_q, res_q;

   logic [DATA_W-1:0] rd_a, rd_b;
   logic              b_bit, r_bit, c_out;
   logic              last, wr_ok, commit_wr, load_wr, rf_we;
   logic [DATA_W-1:0] final_res;
   logic [AW-1:0]     rf_waddr;
   logic [DATA_W-1:0] rf_wdata;

   assign last      = busy_q && (cnt_q == LAST);
   assign wr_ok     = !(q_fen && !flag_q);
   assign final_res = {r_bit, res_q[DATA_W-1:1]};
   assign commit_wr = last && wr_ok;
   assign load_wr   = ld_en && !busy_q && !issue;
   assign rf_we     = commit_wr || load_wr;
   assign rf_waddr  = busy_q ? q_dst : ld_addr;
   assign rf_wdata  = busy_q ? final_res : ld_data;

   pe_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (rf_we),
      .waddr   (rf_waddr),
      .wdata   (rf_wdata),
      .raddr_a (f_src),
      .rdata_a (rd_a),
      .raddr_b (f_dst),
      .rdata_b (rd_b),
      .raddr_c (rd_addr),
      .rdata_c (rd_data)
   );

   pe_nbr_mux #(.NNBR(NNBR)) u_mux (
      .nbr_in  (nbr_in),
      .sel     (q_nsel),
      .use_nbr (q_nbr),
      .own_bit (opb_q[0]),
      .b_bit   (b_bit)
   );

   pe_bit_alu u_alu (
      .op   (q_op),
      .a    (opa_q[0]),
      .b    (b_bit),
      .cin  (carry_q),
      .r    (r_bit),
      .cout (c_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         flag_q  <= 1'b0;
         carry_q <= 1'b0;
         cnt_q   <= '0;
         opa_q   <= '0;
         opb_q   <= '0;
         shout_q <= '0;
         res_q   <= '0;
         q_op    <= OP_ADD;
         q_fmode <= FL_KEEP;
         q_dst   <= '0;
         q_nsel  <= '0;
         q_nbr   <= 1'b0;
         q_fen   <= 1'b0;
      end else if (!busy_q) begin
         if (issue) begin
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            opa_q   <= rd_a;
            opb_q   <= rd_b;
            shout_q <= rd_a;
            carry_q <= carry_seed(pe_op_e'(instr_op));
            q_op    <= pe_op_e'(instr_op);
            q_fmode <= pe_fmode_e'(instr_fmode);
            q_dst   <= f_dst;
            q_nsel  <= f_nsel;
            q_nbr   <= instr_nbr;
            q_fen   <= instr_fen;
         end
      end else begin
         opa_q   <= opa_q >> 1;
         opb_q   <= opb_q >> 1;
         shout_q <= shout_q >> 1;
         res_q   <= final_res;
         carry_q <= c_out;
         cnt_q   <= cnt_q + 1'b1;
         if (last) begin
            busy_q <= 1'b0;
            unique case (q_fmode)
               FL_CARRY: flag_q <= c_out;
               FL_ZERO:  flag_q <= (final_res == '0);
               FL_NZERO: flag_q <= (final_res != '0);
               default:  flag_q <= flag_q;
            endcase
         end
      end
   end

   assign ser_out = shout_q[0];
   assign busy    = busy_q;
   assign flag    = flag_q;

   // R3
   issue_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && issue) |=> (busy_q && cnt_q == '0));

   // R3
   reissue_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != LAST) |=> (busy_q && cnt_q == CW'($past(cnt_q) + 1'b1)));

   // R8
   idle_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !ser_out);

   // R9
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !last |=> $stable(flag_q));

   // R2 R10
   rf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy_q && !(last && wr_ok)) && rd_addr == $past(rd_addr))
         |-> rd_data == $past(rd_data));
endmodule

// File: tb/serial_pe_bench.sv
`timescale 1ns/1ps
module serial_pe_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       issue = 1'b0;
   logic [2:0] instr_op = '0;
   logic [7:0] instr_regs = '0;
   logic       instr_nbr = 1'b0;
   logic [1:0] instr_fmode = '0;
   logic       instr_fen = 1'b0;
   logic [3:0] nbr_in = '0;
   logic       ser_out, busy, flag;
   logic       ld_en = 1'b0;
   logic [2:0] ld_addr = '0;
   logic [7:0] ld_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;

   int vectors = 0;
   int fails = 0;
   int model [8];
   int mflag = 0;

   always #2.5 clk = ~clk;

   serial_pe u_serial_pe (
      .clk(clk), .rst_n(rst_n), .issue(issue), .instr_op(instr_op),
      .instr_regs(instr_regs), .instr_nbr(instr_nbr), .instr_fmode(instr_fmode),
      .instr_fen(instr_fen), .nbr_in(nbr_in), .ser_out(ser_out), .busy(busy),
      .flag(flag), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int pick(input int i);
      case (i % 20)
         0: return 0;
         1: return 255;
         2: return 1;
         3: return 128;
         4: return 127;
         default: return (i * 73 + 29) % 256;
      endcase
   endfunction

   task automatic load(input int addr, input int val);
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 3'(addr); ld_data = 8'(val);
      @(posedge clk);
      @(negedge clk);
      ld_en = 1'b0;
      model[addr] = val;
      rd_addr = 3'(addr);
      #1 check("R2 load readback", int'(rd_data), val);
   endtask

   task automatic run_op(input int op, input int src, input int dst, input bit un,
                         input int ns, input int fm, input bit fe, input int nv,
                         input bit reiss, input bit lddur);
      int a, b, r, c, s;
      bit wr;
      string tag;
      a = model[src];
      b = un ? nv : model[dst];
      c = 0;
      case (op)
         0: begin s = a + b; r = s & 255; c = s >> 8; end
         1: begin s = a + (255 - b) + 1; r = s & 255; c = s >> 8; end
         2: r = a & b;
         3: r = a | b;
         4: r = a ^ b;
         5: r = a;
         6: r = b;
         default: r = 255 - a;
      endcase
      wr = !(fe && mflag == 0);
      tag = (op == 0) ? "R4" : (op == 1) ? "R5" : "R6";
      if (!wr) tag = "R10";
      else if (un) tag = "R7";

      @(negedge clk);
      issue = 1'b1; instr_op = 3'(op);
      instr_regs = {2'(ns), 3'(dst), 3'(src)};
      instr_nbr = un; instr_fmode = 2'(fm); instr_fen = fe;
      @(posedge clk);
      @(negedge clk);
      issue = 1'b0;
      for (int k = 0; k < 8; k++) begin
         bit lane;
         lane = 1'((nv >> k) & 1);
         nbr_in = lane ? 4'b0000 : 4'b1111;
         nbr_in[ns] = lane;
         issue = reiss && (k == 4);
         ld_en = lddur && (k == 2);
         ld_addr = 3'd7;
         ld_data = 8'(model[7] ^ 8'h5A);
         #1;
         check("R8 serial bit", int'(ser_out), (a >> k) & 1);
         check("R3 busy during pass", int'(busy), 1);
         @(posedge clk);
         @(negedge clk);
         issue = 1'b0; ld_en = 1'b0;
      end
      if (wr) model[dst] = r;
      case (fm)
         1: mflag = c;
         2: mflag = (r == 0) ? 1 : 0;
         3: mflag = (r != 0) ? 1 : 0;
         default: ;
      endcase
      rd_addr = 3'(dst);
      #1;
      check({tag, " result"}, int'(rd_data), model[dst]);
      check("R9 flag", int'(flag), mflag);
      check("R3 busy cleared", int'(busy), 0);
      check("R8 idle serial", int'(ser_out), 0);
      if (lddur) begin
         rd_addr = 3'd7;
         #1 check("R2 load ignored while busy", int'(rd_data), model[7]);
      end
      if (reiss) begin
         @(negedge clk);
         check("R3 reissue ignored", int'(busy), 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) model[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1
      check("R1 busy", int'(busy), 0);
      check("R1 flag", int'(flag), 0);
      check("R1 ser_out", int'(ser_out), 0);
      for (int i = 0; i < 8; i++) begin
         rd_addr = 3'(i);
         #1 check("R1 register", int'(rd_data), 0);
      end

      load(7, 8'h3C);

      // R4 R5 R6 R9 R10 sweep over local operands
      for (int op = 0; op < 8; op++) begin
         for (int i = 0; i < 16; i++) begin
            int src, dst;
            src = i % 7;
            dst = (i == 15) ? src : (i + 3) % 7;
            load(src, pick(i));
            if (dst != src) load(dst, pick(i + 5 + op));
            run_op(op, src, dst, 1'b0, i % 4, i % 4, ((i / 4) % 2) == 1,
                   pick(i + 2), i == 7, i == 9);
         end
      end

      // R7 neighbour operand on every lane
      for (int ns = 0; ns < 4; ns++) begin
         for (int j = 0; j < 4; j++) begin
            int op;
            op = (j == 0) ? 0 : (j == 1) ? 6 : (j == 2) ? 2 : 1;
            load(1, pick(ns * 3 + j + 6));
            load(2, pick(ns * 7 + j));
            run_op(op, 1, 2, 1'b1, ns, 1, 1'b0, pick(ns * 5 + j + 1), 1'b0, 1'b0);
         end
      end

      // R10 directed: clear flag, suppressed write, then set flag, write lands
      load(3, 10);
      load(4, 20);
      run_op(1, 3, 4, 1'b0, 0, 1, 1'b0, 0, 1'b0, 1'b0);
      check("R5 borrow clears flag", int'(flag), 0);
      load(5, 99);
      run_op(5, 3, 5, 1'b0, 0, 3, 1'b1, 0, 1'b0, 1'b0);
      check("R10 suppressed write", model[5], 99);
      run_op(5, 3, 5, 1'b0, 0, 0, 1'b1, 0, 1'b0, 1'b0);
      check("R10 enabled write", model[5], 10);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule